// File: doc/BRIEF.md
# USB Endpoint Stall Control Unit

This unit keeps one stall flag for each of the four endpoints of a USB function controller. Software reads and sets the flags through a 32-bit register. On the transaction side, the unit captures the addressed endpoint's flag when a transaction starts. It then presents a handshake override code until the transaction ends. The packet engine uses that code to answer STALL in place of its normal ACK or NAK.

Endpoint 0 has two extra rules.

- Its flag clears itself when a setup command of eight bytes has been received.
- Software cannot set it while the setup-status input is high.

The flags for endpoints 1 to 3 change only through register writes or reset.

Top module: `usb_ep_halt_ctl`

## Requirements
- R1: After reset, all stall flags are 0, `reg_rdata` is 0 and `hs_code` is 00.
- R2: A cycle with `reg_wr` high loads `reg_wdata[3:0]` into the flags. Bit n is endpoint n. The new value appears on `reg_rdata[3:0]` from the next cycle.
- R3: `reg_rdata[31:4]` always reads 0, whatever value has been written to those bits.
- R4: The flags for endpoints 1 to 3 keep their value in every cycle without a register write. `setup_rcvd` never changes them.
- R5: A cycle with `setup_rcvd` high clears the endpoint 0 flag from the next cycle.
- R6: While `setup_flag` is high, a write of 1 to bit 0 leaves the endpoint 0 flag unchanged. A write of 0 to bit 0 still clears it.
- R7: When `setup_rcvd` and a register write of 1 to bit 0 fall in the same cycle, the endpoint 0 flag ends up 0.
- R8: On a cycle with `txn_start` high, the unit samples the flag of endpoint `txn_ep`. From the next cycle through the cycle of `txn_end`, `hs_code` is 01 if that flag was set and 00 if it was clear. After a cycle with `txn_end` and no `txn_start`, `hs_code` returns to 00. The code 01 means STALL and 00 means no override.
- R9: A register write or a setup clear that occurs during a transaction does not change `hs_code` before the next `txn_start`.
- R10: A transaction addressed to endpoint 4 to 15 yields `hs_code` 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| txn_ep | input | 4 | Endpoint number of the current transaction |
| txn_start | input | 1 | Transaction start strobe |
| txn_end | input | 1 | Transaction end strobe |
| setup_rcvd | input | 1 | Eight-byte setup command received |
| setup_flag | input | 1 | Setup-status flag; blocks setting endpoint 0 stall |
| hs_code | output | 2 | Handshake override: 00 none, 01 STALL |

## Verification
Every cycle, the assertions check the following.

- Flags 1 to 3 never move without a write.
- A setup reception always leaves endpoint 0 unstalled.
- A clear endpoint 0 flag cannot become set while `setup_flag` is high.
- `hs_code` stays frozen inside a transaction and drops to 00 after its end.

Only the bench's scenarios can show the following.

- The correct flag is chosen for each endpoint number, including numbers outside 0 to 3.
- Reserved bits read back as zero after writes of all ones.
- The automatic clear wins over a same-cycle set.
- A write made mid-transaction first shows up in the following transaction.

// File: rtl/usb_ep_halt_ctl.sv
module usb_ep_halt_ctl #(
  parameter int NUM_EP = 4,
  parameter int EPN_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EPN_W-1:0]  txn_ep,
  input  logic              txn_start,
  input  logic              txn_end,
  input  logic              setup_rcvd,
  input  logic              setup_flag,
  output logic [1:0]        hs_code
);

  logic [NUM_EP-1:0] halt_q, halt_d, ep_mask;
  logic              txn_halt_q;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_EP];

  always_comb begin
    halt_d = halt_q;
    if (reg_wr) halt_d = reg_wdata[NUM_EP-1:0];
    if (reg_wr && setup_flag && reg_wdata[0]) halt_d[0] = halt_q[0];
    if (setup_rcvd) halt_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) halt_q <= '0;
    else        halt_q <= halt_d;
  end

  assign ep_mask = NUM_EP'(1) << txn_ep;

  always_ff @(posedge clk) begin
    if (!rst_n)         txn_halt_q <= 1'b0;
    else if (txn_start) txn_halt_q <= |(halt_q & ep_mask);
    else if (txn_end)   txn_halt_q <= 1'b0;
  end

  assign hs_code   = {1'b0, txn_halt_q};
  assign reg_rdata = DATA_W'(halt_q);

  // R4
  ep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(halt_q[NUM_EP-1:1]));

  // R5
  setup_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rcvd |=> !reg_rdata[0]);

  // R6
  blocked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_flag && !reg_rdata[0]) |=> !reg_rdata[0]);

  // R9
  hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_start && !txn_end) |=> $stable(hs_code));

  // R8
  hs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !txn_start) |=> hs_code == 2'b00);

endmodule

// File: tb/usb_ep_halt_ctl_tb.sv
module usb_ep_halt_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  txn_ep = '0;
  logic        txn_start = 1'b0;
  logic        txn_end = 1'b0;
  logic        setup_rcvd = 1'b0;
  logic        setup_flag = 1'b0;
  logic [1:0]  hs_code;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  usb_ep_halt_ctl u_dut (
    .clk, .rst_n, .reg_wr, .reg_wdata, .reg_rdata, .txn_ep,
    .txn_start, .txn_end, .setup_rcvd, .setup_flag, .hs_code
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic start(input logic [3:0] ep);
    txn_start = 1'b1; txn_ep = ep;
    @(negedge clk);
    txn_start = 1'b0;
  endtask

  task automatic stop();
    txn_end = 1'b1;
    @(negedge clk);
    txn_end = 1'b0;
  endtask

  // {stall pattern, endpoint, expected hs_code}
  localparam logic [9:0] VEC [10] = '{
    {4'b0001, 4'd0,  2'b01}, {4'b0001, 4'd1,  2'b00},
    {4'b0110, 4'd1,  2'b01}, {4'b0110, 4'd2,  2'b01},
    {4'b0110, 4'd3,  2'b00}, {4'b1000, 4'd3,  2'b01},
    {4'b1111, 4'd7,  2'b00}, {4'b1111, 4'd15, 2'b00},
    {4'b0000, 4'd2,  2'b00}, {4'b1010, 4'd1,  2'b01}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 hs_code", {30'b0, hs_code}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      wr({28'b0, VEC[i][9:6]});
      chk("R2 readback", reg_rdata, {28'b0, VEC[i][9:6]});
      start(VEC[i][5:2]);
      chk("R8/R10 hs_code", {30'b0, hs_code}, {30'b0, VEC[i][1:0]});
      @(negedge clk);
      chk("R8 hold", {30'b0, hs_code}, {30'b0, VEC[i][1:0]});
      stop();
      chk("R8 release", {30'b0, hs_code}, 32'h0);
    end

    wr(32'hFFFF_FFFF);
    chk("R3 reserved zero", reg_rdata, 32'h0000_000F);

    setup_rcvd = 1'b1;
    @(negedge clk);
    setup_rcvd = 1'b0;
    chk("R5 ep0 cleared, R4 ep1-3 kept", reg_rdata, 32'h0000_000E);
    repeat (3) @(negedge clk);
    chk("R4 idle hold", reg_rdata, 32'h0000_000E);

    setup_flag = 1'b1;
    wr(32'h0000_0001);
    chk("R6 set blocked", reg_rdata, 32'h0000_0001 & 32'h0);
    setup_flag = 1'b0;
    wr(32'h0000_0001);
    chk("R6 set allowed flag low", reg_rdata, 32'h0000_0001);
    setup_flag = 1'b1;
    wr(32'h0000_0003);
    chk("R6 keep ep0 while flag high", reg_rdata, 32'h0000_0003);
    wr(32'h0000_0002);
    chk("R6 clear allowed while flag high", reg_rdata, 32'h0000_0002);
    setup_flag = 1'b0;

    setup_rcvd = 1'b1;
    wr(32'h0000_0005);
    setup_rcvd = 1'b0;
    chk("R7 auto clear wins", reg_rdata, 32'h0000_0004);

    wr(32'h0000_0000);
    start(4'd2);
    chk("R9 before write", {30'b0, hs_code}, 32'h0);
    wr(32'h0000_0004);
    chk("R9 mid-txn write no effect", {30'b0, hs_code}, 32'h0);
    stop();
    start(4'd2);
    chk("R9 next txn sees write", {30'b0, hs_code}, 32'h1);
    stop();

    wr(32'h0000_0001);
    start(4'd0);
    setup_rcvd = 1'b1;
    @(negedge clk);
    setup_rcvd = 1'b0;
    chk("R9 setup clear mid-txn", {30'b0, hs_code}, 32'h1);
    chk("R5 ep0 cleared mid-txn", reg_rdata, 32'h0);
    stop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule